// File: doc/BRIEF.md
# Software-Acknowledge Message Sink

This block receives broadcast messages at the destination side of a node and keeps them until local software has dealt with them. Every accepted message is stored as a 256-bit entry in a circular payload queue of seventeen slots. A message that asks for software acknowledgement is bound to one of eight acknowledge resources. The one-hot code of that resource goes into byte 15 of the stored entry. While the resource is held, an interrupt line stays raised toward the local processors.

Software frees a resource by writing the acknowledge alias port. Each resource has a pending bit and a timeout bit. When a held resource frees normally, the block issues one reply. A resource that runs past its programmable timeout produces an error reply at once. It then stays held until software clears it, and that clear issues no second reply. When every resource is held, a new message that needs acknowledgement is held off through back-pressure and is not dropped.

Top module: `swack_msg_sink`

## Requirements
- R1: After reset all pending and timeout bits are zero, the queue tail is 0, both interrupt lines and `rep_valid` are low, and `msg_ready` is high.
- R2: An accepted message with `msg_ack_req`=1 takes the lowest-numbered free resource r. After the accepting edge, status bit r (`ack_status[r]`) reads 1.
- R3: The entry written at the tail holds the payload in bits 95:0 and `msg_hdr_lo` in bits 119:96. It holds the resource vector in bits 127:120, with bit r set for resource r. It holds `msg_hdr_hi` in bits 143:128, and every other bit is zero.
- R4: Each accepted message advances the tail by one. From slot 16 the tail wraps to slot 0.
- R5: When all 8 resources are held and `msg_ack_req`=1, `msg_ready` is low, and neither the tail nor the status changes.
- R6: On an `ack_wdata` write, bit r clears the pending bit of resource r and bit r+8 clears its timeout bit. If resource r is pending and has not timed out, the clear issues exactly one non-error reply for r. That reply appears on `rep_valid` in the second cycle after the write edge.
- R7: A resource still pending `tmo_limit` cycles after delivery sets its timeout bit (status bit r+8). One cycle later it issues one error reply (`rep_err`=1). It stays held.
- R8: Clearing a timed-out resource with both bits frees it and issues no further reply.
- R9: `irq_sock0` is high while any resource is pending and not timed out. `irq_sock1` is high only while such a resource came from a message with `msg_both`=1.
- R10: A message with `msg_ack_req`=0 takes no resource and is stored with vector 0. It raises `irq_sock0` for one cycle, and `irq_sock1` as well when `msg_both`=1. It produces no reply.
- R11: At most one reply leaves per cycle. When several are owed, the lowest resource number goes first.
- R12: A `tmo_limit` of 0 disables timeouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Message can be accepted this cycle |
| msg_ack_req | input | 1 | Message waits for software acknowledge |
| msg_both | input | 1 | Interrupt both sockets for this message |
| msg_payload | input | 96 | Payload bytes 0 to 11 |
| msg_hdr_lo | input | 24 | Header bits 58 to 81, stored as bytes 12 to 14 |
| msg_hdr_hi | input | 16 | Header bits 41 to 56, stored as bytes 16 to 17 |
| ack_we | input | 1 | Acknowledge alias write strobe |
| ack_wdata | input | 16 | Clear mask: pending in 7:0, timeout in 15:8 |
| tmo_limit | input | 16 | Timeout in cycles, 0 disables |
| ack_status | output | 16 | Pending bits 7:0, timeout bits 15:8 |
| irq_sock0 | output | 1 | Interrupt to socket 0 |
| irq_sock1 | output | 1 | Interrupt to socket 1 |
| rep_valid | output | 1 | Reply issued this cycle |
| rep_err | output | 1 | Reply is an error (timeout) reply |
| rep_res | output | 3 | Resource the reply belongs to |
| q_tail | output | 5 | Next queue slot to be written |
| rd_idx | input | 5 | Queue slot to read |
| rd_entry | output | 256 | Contents of slot `rd_idx` |

## Verification
The assertions check several properties on every cycle. Back-pressure is never absent while every resource is held. The tail stays in range and wraps from the last slot to slot 0. Timeout bits stay set until a write clears them. A raised pending-and-live resource always shows on socket 0. The same resource never replies twice in a row. Other properties need the bench's scenarios. These are which resource is chosen and what the stored entry holds. They also include the exact cycle of the timeout and the error reply, and the absence of a second reply after a timed-out clear. The last two are the ordering of replies owed together and the one-cycle interrupt pulse of messages without acknowledgement.

// File: rtl/swack_pkg.sv
// Shared constants and entry packing for the software-acknowledge message sink.
// Assumes the stored entry is 256 bits wide and the vector byte is byte 15.
package swack_pkg;
    localparam int ENTRY_W   = 256;
    localparam int PAYLOAD_W = 96;
    localparam int HDR_LO_W  = 24;
    localparam int HDR_HI_W  = 16;
    localparam int VEC_W     = 8;

    // Packs the message fields into the queue entry layout.
    function automatic logic [ENTRY_W-1:0] pack_entry(
        input logic [PAYLOAD_W-1:0] payload,
        input logic [HDR_LO_W-1:0]  hdr_lo,
        input logic [VEC_W-1:0]     vec,
        input logic [HDR_HI_W-1:0]  hdr_hi
    );
        logic [ENTRY_W-1:0] e;
        e = '0;
        e[95:0]    = payload;
        e[119:96]  = hdr_lo;
        e[127:120] = vec;
        e[143:128] = hdr_hi;
        return e;
    endfunction
endpackage

// File: rtl/swack_rsrc_slot.sv
// One software-acknowledge resource: pending and timeout state, the timeout
// counter and the owed-reply flag. Assumes alloc only arrives when busy is low.
module swack_rsrc_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             alloc_both,
    input  logic             clr_pend,
    input  logic             clr_tmo,
    input  logic [CNT_W-1:0] limit,
    input  logic             grant,
    output logic             pend,
    output logic             tmo,
    output logic             both,
    output logic             owe,
    output logic             owe_err,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    // Resource state machine: allocate, count, time out, clear, owe reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            tmo     <= 1'b0;
            both    <= 1'b0;
            owe     <= 1'b0;
            owe_err <= 1'b0;
            cnt     <= '0;
        end else begin
            if (grant) begin
                owe <= 1'b0;
            end
            if (alloc) begin
                pend <= 1'b1;
                tmo  <= 1'b0;
                both <= alloc_both;
                cnt  <= '0;
            end else if (pend && !tmo) begin
                if (clr_pend) begin
                    pend    <= 1'b0;
                    owe     <= 1'b1;
                    owe_err <= 1'b0;
                end else if (limit != '0 && cnt == limit - CNT_W'(1)) begin
                    tmo     <= 1'b1;
                    owe     <= 1'b1;
                    owe_err <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else begin
                if (clr_pend) begin
                    pend <= 1'b0;
                end
                if (clr_tmo) begin
                    tmo <= 1'b0;
                end
            end
        end
    end

    // A resource is reusable only with both bits clear and no reply owed.
    always_comb busy = pend | tmo | owe;
endmodule

// File: rtl/swack_reply_arb.sv
// Picks one owed reply per cycle, lowest resource first, and registers it.
// Assumes owe bits stay set until their grant.
module swack_reply_arb #(
    parameter int NUM_RES = 8,
    localparam int RES_W  = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_RES-1:0] owe,
    input  logic [NUM_RES-1:0] owe_err,
    output logic [NUM_RES-1:0] grant,
    output logic               rep_valid,
    output logic               rep_err,
    output logic [RES_W-1:0]   rep_res
);
    logic             found;
    logic [RES_W-1:0] pick;

    // Lowest-index owed reply wins.
    always_comb begin
        grant = '0;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NUM_RES; i++) begin
            if (owe[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                pick     = RES_W'(i);
            end
        end
    end

    // Registered reply output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_valid <= 1'b0;
            rep_err   <= 1'b0;
            rep_res   <= '0;
        end else begin
            rep_valid <= found;
            rep_err   <= |(grant & owe_err);
            rep_res   <= pick;
        end
    end
endmodule

// File: rtl/swack_payload_queue.sv
// Circular store of message entries with a tail that wraps from the last
// slot to the first. Assumes software drains entries before they are reused.
module swack_payload_queue #(
    parameter int DEPTH   = 17,
    parameter int ENTRY_W = 256,
    localparam int QA_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] wr_entry,
    output logic [QA_W-1:0]    tail,
    input  logic [QA_W-1:0]    rd_idx,
    output logic [ENTRY_W-1:0] rd_entry
);
    localparam logic [QA_W-1:0] LAST = QA_W'(DEPTH - 1);

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Write the entry at the tail and advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push) begin
            mem[tail] <= wr_entry;
            tail      <= (tail == LAST) ? '0 : tail + QA_W'(1);
        end
    end

    // Read port for software, zero outside the queue.
    always_comb rd_entry = (rd_idx <= LAST) ? mem[rd_idx] : '0;
endmodule

// File: rtl/swack_msg_sink.sv
// Destination-side message sink: stores messages in the payload queue,
// binds acknowledge resources, raises socket interrupts and issues replies.
// Assumes NUM_RES is at most 8 so the vector fits byte 15 of the entry.
module swack_msg_sink #(
    parameter int NUM_RES = 8,
    parameter int Q_DEPTH = 17,
    parameter int CNT_W   = 16,
    localparam int RES_W  = $clog2(NUM_RES),
    localparam int QA_W   = $clog2(Q_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    output logic                 msg_ready,
    input  logic                 msg_ack_req,
    input  logic                 msg_both,
    input  logic [95:0]          msg_payload,
    input  logic [23:0]          msg_hdr_lo,
    input  logic [15:0]          msg_hdr_hi,
    input  logic                 ack_we,
    input  logic [2*NUM_RES-1:0] ack_wdata,
    input  logic [CNT_W-1:0]     tmo_limit,
    output logic [2*NUM_RES-1:0] ack_status,
    output logic                 irq_sock0,
    output logic                 irq_sock1,
    output logic                 rep_valid,
    output logic                 rep_err,
    output logic [RES_W-1:0]     rep_res,
    output logic [QA_W-1:0]      q_tail,
    input  logic [QA_W-1:0]      rd_idx,
    output logic [255:0]         rd_entry
);
    import swack_pkg::*;

    logic [NUM_RES-1:0] pend, tmo, both, owe, owe_err, busy, grant;
    logic [NUM_RES-1:0] alloc_oh, alloc;
    logic               any_free, accept;
    logic [VEC_W-1:0]   vec;
    logic               nack_q, nack_both_q;

    // Lowest free resource as a one-hot code.
    always_comb begin
        alloc_oh = '0;
        any_free = 1'b0;
        for (int i = 0; i < NUM_RES; i++) begin
            if (!busy[i] && !any_free) begin
                any_free    = 1'b1;
                alloc_oh[i] = 1'b1;
            end
        end
    end

    // Acceptance and back-pressure.
    always_comb begin
        msg_ready = !msg_ack_req || any_free;
        accept    = msg_valid && msg_ready;
        alloc     = (accept && msg_ack_req) ? alloc_oh : '0;
    end

    // Resource vector written into byte 15.
    always_comb begin
        vec = '0;
        if (msg_ack_req) begin
            vec[NUM_RES-1:0] = alloc_oh;
        end
    end

    generate
        for (genvar r = 0; r < NUM_RES; r++) begin : g_rsrc
            swack_rsrc_slot #(.CNT_W(CNT_W)) i_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc     (alloc[r]),
                .alloc_both(msg_both),
                .clr_pend  (ack_we && ack_wdata[r]),
                .clr_tmo   (ack_we && ack_wdata[NUM_RES + r]),
                .limit     (tmo_limit),
                .grant     (grant[r]),
                .pend      (pend[r]),
                .tmo       (tmo[r]),
                .both      (both[r]),
                .owe       (owe[r]),
                .owe_err   (owe_err[r]),
                .busy      (busy[r])
            );
        end
    endgenerate

    swack_reply_arb #(.NUM_RES(NUM_RES)) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .owe      (owe),
        .owe_err  (owe_err),
        .grant    (grant),
        .rep_valid(rep_valid),
        .rep_err  (rep_err),
        .rep_res  (rep_res)
    );

    swack_payload_queue #(.DEPTH(Q_DEPTH), .ENTRY_W(ENTRY_W)) i_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (accept),
        .wr_entry(pack_entry(msg_payload, msg_hdr_lo, vec, msg_hdr_hi)),
        .tail    (q_tail),
        .rd_idx  (rd_idx),
        .rd_entry(rd_entry)
    );

    // One-cycle interrupt pulse for messages that need no acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack_q      <= 1'b0;
            nack_both_q <= 1'b0;
        end else begin
            nack_q      <= accept && !msg_ack_req;
            nack_both_q <= accept && !msg_ack_req && msg_both;
        end
    end

    // Status and level interrupts.
    always_comb begin
        ack_status = {tmo, pend};
        irq_sock0  = (|(pend & ~tmo)) || nack_q;
        irq_sock1  = (|(pend & ~tmo & both)) || nack_both_q;
    end
endmodule

// File: rtl/swack_msg_sink_chk.sv
// Property checker for swack_msg_sink, observing its ports only.
module swack_msg_sink_chk #(
    parameter int NUM_RES = 8,
    parameter int Q_DEPTH = 17,
    localparam int RES_W  = $clog2(NUM_RES),
    localparam int QA_W   = $clog2(Q_DEPTH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic                 msg_ack_req,
    input logic                 ack_we,
    input logic [2*NUM_RES-1:0] ack_wdata,
    input logic [2*NUM_RES-1:0] ack_status,
    input logic                 irq_sock0,
    input logic                 irq_sock1,
    input logic                 rep_valid,
    input logic [RES_W-1:0]     rep_res,
    input logic [QA_W-1:0]      q_tail
);
    logic [NUM_RES-1:0] pend_v, tmo_v;
    assign pend_v = ack_status[NUM_RES-1:0];
    assign tmo_v  = ack_status[2*NUM_RES-1:NUM_RES];

    a_r5_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ack_req && (&(pend_v | tmo_v))) |-> !msg_ready);

    a_r5_tail_still: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_valid && msg_ready) |=> $stable(q_tail));

    a_r4_tail_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_tail) < Q_DEPTH);

    a_r4_tail_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && int'(q_tail) == Q_DEPTH - 1) |=> q_tail == '0);

    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_v & ~tmo_v)) |-> irq_sock0);

    a_r9_sock1_subset: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sock1 |-> irq_sock0);

    a_r11_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> !(rep_valid && rep_res == $past(rep_res)));

    generate
        for (genvar r = 0; r < NUM_RES; r++) begin : g_tmo
            a_r7_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (tmo_v[r] && !(ack_we && ack_wdata[NUM_RES + r])) |=> tmo_v[r]);
        end
    endgenerate
endmodule

bind swack_msg_sink swack_msg_sink_chk #(.NUM_RES(NUM_RES), .Q_DEPTH(Q_DEPTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_ack_req(msg_ack_req),
    .ack_we     (ack_we),
    .ack_wdata  (ack_wdata),
    .ack_status (ack_status),
    .irq_sock0  (irq_sock0),
    .irq_sock1  (irq_sock1),
    .rep_valid  (rep_valid),
    .rep_res    (rep_res),
    .q_tail     (q_tail)
);

// File: tb/test_swack_msg_sink.sv
// Self-checking bench: directed corner cases plus seeded random traffic.
module test_swack_msg_sink;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         msg_valid = 1'b0, msg_ready, msg_ack_req = 1'b0, msg_both = 1'b0;
    logic [95:0]  msg_payload = '0;
    logic [23:0]  msg_hdr_lo = '0;
    logic [15:0]  msg_hdr_hi = '0;
    logic         ack_we = 1'b0;
    logic [15:0]  ack_wdata = '0;
    logic [15:0]  tmo_limit = '0;
    logic [15:0]  ack_status;
    logic         irq_sock0, irq_sock1, rep_valid, rep_err;
    logic [2:0]   rep_res;
    logic [4:0]   q_tail;
    logic [4:0]   rd_idx = '0;
    logic [255:0] rd_entry;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    swack_msg_sink i_swack_msg_sink (.*);

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: cycles=%0d expected < 100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [255:0] exp_entry(input logic [95:0] p, input logic [23:0] lo,
                                                input logic [7:0] v, input logic [15:0] hi);
        return {112'b0, hi, v, lo, p};
    endfunction

    function automatic logic [7:0] lowest_free(input logic [7:0] held);
        for (int i = 0; i < 8; i++) if (!held[i]) return 8'(1 << i);
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic ack, input logic both, input logic [95:0] p,
                        input logic [23:0] lo, input logic [15:0] hi);
        msg_valid = 1'b1; msg_ack_req = ack; msg_both = both;
        msg_payload = p; msg_hdr_lo = lo; msg_hdr_hi = hi;
        cycle();
        msg_valid = 1'b0; msg_ack_req = 1'b0; msg_both = 1'b0;
    endtask

    task automatic ack_write(input logic [15:0] w);
        ack_we = 1'b1; ack_wdata = w;
        cycle();
        ack_we = 1'b0; ack_wdata = '0;
    endtask

    initial begin
        logic [7:0]  held;
        int          tail_e;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 status", 256'(ack_status), 256'h0);
        chk("R1 tail", 256'(q_tail), 256'h0);
        chk("R1 irq", 256'({irq_sock0, irq_sock1, rep_valid}), 256'h0);
        msg_ack_req = 1'b1; #1;
        chk("R1 ready", 256'(msg_ready), 256'h1);
        msg_ack_req = 1'b0;
        @(negedge clk);

        // R2 R3 R9 first message
        send(1'b1, 1'b0, 96'h0123456789abcdef0a0b0c0d, 24'h112233, 16'h4455);
        rd_idx = 5'd0; #1;
        chk("R2 status", 256'(ack_status), 256'h0001);
        chk("R4 tail step", 256'(q_tail), 256'd1);
        chk("R3 entry", rd_entry, exp_entry(96'h0123456789abcdef0a0b0c0d, 24'h112233, 8'h01, 16'h4455));
        chk("R9 irq sock0 only", 256'({irq_sock0, irq_sock1}), 256'b10);

        send(1'b1, 1'b1, 96'h5, 24'h6, 16'h7);
        rd_idx = 5'd1; #1;
        chk("R2 second resource", 256'(ack_status), 256'h0003);
        chk("R3 vector byte", 256'(rd_entry[127:120]), 256'h02);
        chk("R9 irq sock1", 256'(irq_sock1), 256'h1);

        // R6 normal release and reply
        ack_write(16'h0101);
        chk("R6 cleared", 256'(ack_status), 256'h0002);
        chk("R6 no early reply", 256'(rep_valid), 256'h0);
        cycle();
        chk("R6 reply", 256'({rep_valid, rep_err, rep_res}), 256'({1'b1, 1'b0, 3'd0}));
        cycle();
        chk("R6 single reply", 256'(rep_valid), 256'h0);
        ack_write(16'h0202);
        cycle();
        chk("R6 reply r1", 256'({rep_valid, rep_err, rep_res}), 256'({1'b1, 1'b0, 3'd1}));
        cycle();
        chk("R9 irq idle", 256'({irq_sock0, irq_sock1}), 256'b00);

        // R10 no-acknowledge message
        send(1'b0, 1'b1, 96'h9, 24'ha, 16'hb);
        rd_idx = 5'd2; #1;
        chk("R10 no resource", 256'(ack_status), 256'h0);
        chk("R10 vector zero", 256'(rd_entry[127:120]), 256'h0);
        chk("R10 pulse", 256'({irq_sock0, irq_sock1}), 256'b11);
        cycle();
        chk("R10 pulse ends", 256'({irq_sock0, irq_sock1, rep_valid}), 256'b000);

        // R7 R8 timeout path
        tmo_limit = 16'd5;
        send(1'b1, 1'b0, 96'hc, 24'hd, 16'he);
        repeat (4) cycle();
        chk("R7 not yet", 256'(ack_status), 256'h0001);
        cycle();
        chk("R7 timeout bit", 256'(ack_status), 256'h0101);
        chk("R9 irq drops on timeout", 256'(irq_sock0), 256'h0);
        cycle();
        chk("R7 error reply", 256'({rep_valid, rep_err, rep_res}), 256'({1'b1, 1'b1, 3'd0}));
        repeat (3) cycle();
        chk("R7 still held", 256'(ack_status), 256'h0101);
        ack_write(16'h0101);
        chk("R8 freed", 256'(ack_status), 256'h0);
        for (int k = 0; k < 3; k++) begin
            chk("R8 no second reply", 256'(rep_valid), 256'h0);
            cycle();
        end

        // R5 R12 fill all resources
        tmo_limit = 16'd0;
        for (int k = 0; k < 8; k++) send(1'b1, 1'b0, 96'(k), 24'h0, 16'h0);
        chk("R5 all held", 256'(ack_status), 256'h00ff);
        chk("R4 tail", 256'(q_tail), 256'd12);
        msg_valid = 1'b1; msg_ack_req = 1'b1; #1;
        chk("R5 ready low", 256'(msg_ready), 256'h0);
        cycle(); cycle();
        chk("R5 tail unchanged", 256'(q_tail), 256'd12);
        chk("R5 status unchanged", 256'(ack_status), 256'h00ff);
        msg_valid = 1'b0; msg_ack_req = 1'b0;
        repeat (20) cycle();
        chk("R12 no timeout", 256'(ack_status), 256'h00ff);

        // R11 several replies owed
        ack_write(16'h0006);
        cycle();
        chk("R11 first", 256'({rep_valid, rep_res}), 256'({1'b1, 3'd1}));
        cycle();
        chk("R11 second", 256'({rep_valid, rep_res}), 256'({1'b1, 3'd2}));
        ack_write(16'h00f9);
        foreach (held[k]) begin end
        for (int k = 0; k < 8; k++) begin
            if (k == 1 || k == 2) continue;
            cycle();
            chk("R11 order", 256'({rep_valid, rep_res}), 256'({1'b1, 3'(k)}));
        end
        cycle();
        chk("R11 done", 256'(rep_valid), 256'h0);

        // R4 wrap
        for (int k = 0; k < 4; k++) send(1'b0, 1'b0, 96'h0, 24'h0, 16'h0);
        chk("R4 last slot", 256'(q_tail), 256'd16);
        send(1'b0, 1'b0, 96'hfeed, 24'hbeef, 16'hcafe);
        rd_idx = 5'd16; #1;
        chk("R4 wrapped", 256'(q_tail), 256'd0);
        chk("R3 entry at last slot", rd_entry, exp_entry(96'hfeed, 24'hbeef, 8'h00, 16'hcafe));
        cycle();

        // Random traffic, R2 R3 R6 checked against a bench model
        held   = '0;
        tail_e = 0;
        for (int it = 0; it < 300; it++) begin
            if (held != 8'hff && ($urandom % 2 == 0 || held == 8'h00)) begin
                logic [7:0]  v;
                logic [95:0] p;
                v = lowest_free(held);
                p = {$urandom, $urandom, $urandom};
                send(1'b1, 1'b0, p, 24'(it), 16'(~it));
                rd_idx = 5'(tail_e); #1;
                held   = held | v;
                tail_e = (tail_e + 1) % 17;
                chk("R2 random alloc", 256'(ack_status), 256'({8'h00, held}));
                chk("R3 random entry", rd_entry, exp_entry(p, 24'(it), v, 16'(~it)));
                chk("R4 random tail", 256'(q_tail), 256'(tail_e));
            end else begin
                int r;
                r = $urandom % 8;
                while (!held[r]) r = (r + 1) % 8;
                ack_write(16'((1 << r) | (1 << (r + 8))));
                cycle();
                held[r] = 1'b0;
                chk("R6 random reply", 256'({rep_valid, rep_err, rep_res}), 256'({1'b1, 1'b0, 3'(r)}));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule